// File: doc/BRIEF.md
# Sync-and-Trigger Capture Timebase

This block is the free-running or event-controlled counter that an input capture channel samples when an edge arrives. It advances by one on each clock-enable tick supplied by an upstream clock selector. A five-bit source code and one trigger-mode bit together select one of four behaviours:
- **Plain counting:** the counter simply runs.
- **Synchronous:** the counter is zeroed by a pulse on a chosen internal line and keeps counting afterwards.
- **Hardware trigger:** the counter waits at zero until a pulse arrives on the chosen line.
- **Software trigger:** the counter waits at zero until software writes the trigger status high.

The trigger status flag stays set after a trigger is accepted. It remains set until software writes it low, which sends the counter back to waiting. Setting the elaboration option `CASCADE` builds two counter halves that act as one double-width counter. In that case the sync and trigger controls drive both halves together.

Top module: `capture_timebase`

## Requirements
- R1: After reset the count output is zero and the trigger status is low.
- R2: With source code 0 and the trigger-mode bit low, the count rises by exactly one on each clock edge where the tick input is high, and holds its value on edges where the tick is low.
- R3: The count wraps from all ones (16'hFFFF for a single half) to zero on the next tick.
- R4: With trigger mode low and source code N in 1..30, a high level on the pulse-vector bit N-1 at a clock edge zeroes the count on that edge, even if the tick is also high. Counting resumes on later ticks. High levels on the other bits of the pulse vector have no effect.
- R5: With trigger mode high and source code N in 1..30, the count is held at zero and the status stays low until the pulse-vector bit N-1 is high at an edge. That edge sets the status, and the count advances on ticks from the following edge onwards.
- R6: With source code 0 and trigger mode high, pulses on the pulse vector are ignored. The count stays at zero until a write with value 1 sets the status.
- R7: Once set, the status stays high until a write with value 0. After that write the status is low, and from the next edge the count is held at zero. A write takes priority over a hardware trigger pulse arriving at the same edge.
- R8: While trigger mode is low, the status stays low and writes to it are ignored.
- R9: Source codes 31 and above select no line. In synchronous mode the count is never zeroed by pulses, and in hardware trigger mode the trigger is never accepted.
- R10: With `CASCADE` set, the count is twice the half width. The upper half advances only on a tick where the lower half is all ones, and a sync pulse zeroes both halves.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable from the upstream clock selector |
| src_sel | input | SEL_W | Sync/trigger source code; 0 means no hardware source |
| trig_mode | input | 1 | 0 for free or synchronous operation, 1 for trigger operation |
| src_pulse | input | NUM_SRC | Internal sync/trigger pulses; bit N-1 belongs to code N |
| trig_wr | input | 1 | Write strobe for the trigger status |
| trig_wr_val | input | 1 | Value written to the trigger status |
| count | output | HALF_W or 2*HALF_W | Live counter value |
| trig_stat | output | 1 | Trigger accepted flag |

## Verification
Every result in this block comes from a single register stage. Count and status therefore reflect the inputs present at one rising edge, and they are due half a period after that edge. The one exception is a status clear: it zeroes the count one edge later, because the count logic sees the registered status. The bench drives each stimulus at a falling edge and samples at the next falling edge. For a status clear it spends an extra idle vector before expecting zero. The wrap and carry checks run 65535 ticks and then one more before comparing.

// File: rtl/capture_timebase_pkg.sv
package capture_timebase_pkg;

   typedef enum logic [1:0] {
      CTB_FREE   = 2'd0,
      CTB_SYNC   = 2'd1,
      CTB_HWTRIG = 2'd2,
      CTB_SWTRIG = 2'd3
   } ctb_mode_e;

   function automatic ctb_mode_e ctb_decode(input logic no_src, input logic trig);
      if (trig) return no_src ? CTB_SWTRIG : CTB_HWTRIG;
      return no_src ? CTB_FREE : CTB_SYNC;
   endfunction

   function automatic logic ctb_is_trig(input ctb_mode_e m);
      return (m == CTB_HWTRIG) || (m == CTB_SWTRIG);
   endfunction

endpackage

// File: rtl/ctb_src_select.sv
module ctb_src_select #(
   parameter int SEL_W   = 5,
   parameter int NUM_SRC = 30
) (
   input  logic [SEL_W-1:0]   sel,
   input  logic [NUM_SRC-1:0] pulses,
   output logic               hit
);
   logic [NUM_SRC-1:0] match;

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_match
      assign match[i] = (sel == SEL_W'(i + 1));
   end

   assign hit = |(match & pulses);
endmodule

// File: rtl/ctb_trig_ctrl.sv
module ctb_trig_ctrl
   import capture_timebase_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  ctb_mode_e mode,
   input  logic      hit,
   input  logic      wr,
   input  logic      wr_val,
   output logic      stat_q
);
   logic stat_d;

   always_comb begin
      stat_d = stat_q;
      if (!ctb_is_trig(mode))             stat_d = 1'b0;
      else if (wr)                        stat_d = wr_val;
      else if (mode == CTB_HWTRIG && hit) stat_d = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) stat_q <= 1'b0;
      else        stat_q <= stat_d;
   end
endmodule

// File: rtl/ctb_count_half.sv
module ctb_count_half #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] val
);
   always_ff @(posedge clk) begin
      if (!rst_n)   val <= '0;
      else if (clr) val <= '0;
      else if (inc) val <= val + 1'b1;
   end
endmodule

// File: rtl/capture_timebase.sv
module capture_timebase
   import capture_timebase_pkg::*;
#(
   parameter int HALF_W  = 16,
   parameter int SEL_W   = 5,
   parameter int NUM_SRC = 30,
   parameter bit CASCADE = 1'b0,
   localparam int OUT_W  = CASCADE ? 2 * HALF_W : HALF_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick,
   input  logic [SEL_W-1:0]   src_sel,
   input  logic               trig_mode,
   input  logic [NUM_SRC-1:0] src_pulse,
   input  logic               trig_wr,
   input  logic               trig_wr_val,
   output logic [OUT_W-1:0]   count,
   output logic               trig_stat
);
   if (HALF_W < 2) begin : g_bad_width
      $error("HALF_W must be at least 2");
   end
   if (NUM_SRC < 1 || NUM_SRC > (2 ** SEL_W) - 1) begin : g_bad_src
      $error("NUM_SRC must fit in the nonzero codes of SEL_W");
   end

   ctb_mode_e mode;
   logic      hit;
   logic      run;
   logic      clr;
   logic      inc;

   assign mode = ctb_decode(src_sel == '0, trig_mode);

   ctb_src_select #(.SEL_W(SEL_W), .NUM_SRC(NUM_SRC)) u_sel (
      .sel    (src_sel),
      .pulses (src_pulse),
      .hit    (hit)
   );

   ctb_trig_ctrl u_trig (
      .clk    (clk),
      .rst_n  (rst_n),
      .mode   (mode),
      .hit    (hit),
      .wr     (trig_wr),
      .wr_val (trig_wr_val),
      .stat_q (trig_stat)
   );

   assign run = ctb_is_trig(mode) ? trig_stat : 1'b1;
   assign clr = (mode == CTB_SYNC && hit) || (ctb_is_trig(mode) && !trig_stat);
   assign inc = tick && run;

   if (CASCADE) begin : g_cascade
      logic [HALF_W-1:0] lo;
      logic [HALF_W-1:0] hi;
      logic              carry;

      assign carry = inc && (lo == '1);

      ctb_count_half #(.W(HALF_W)) u_lo (
         .clk (clk), .rst_n (rst_n), .clr (clr), .inc (inc), .val (lo)
      );
      ctb_count_half #(.W(HALF_W)) u_hi (
         .clk (clk), .rst_n (rst_n), .clr (clr), .inc (carry), .val (hi)
      );
      assign count = {hi, lo};
   end else begin : g_single
      ctb_count_half #(.W(HALF_W)) u_cnt (
         .clk (clk), .rst_n (rst_n), .clr (clr), .inc (inc), .val (count)
      );
   end
endmodule

// File: rtl/capture_timebase_chk.sv
module capture_timebase_chk #(
   parameter int HALF_W  = 16,
   parameter int SEL_W   = 5,
   parameter int NUM_SRC = 30,
   parameter bit CASCADE = 1'b0,
   localparam int OUT_W  = CASCADE ? 2 * HALF_W : HALF_W
) (
   input logic               clk,
   input logic               rst_n,
   input logic               tick,
   input logic [SEL_W-1:0]   src_sel,
   input logic               trig_mode,
   input logic [NUM_SRC-1:0] src_pulse,
   input logic               trig_wr,
   input logic               trig_wr_val,
   input logic [OUT_W-1:0]   count,
   input logic               trig_stat
);
   logic sel_hit;
   logic free_m;
   logic sync_m;
   logic hw_m;

   always_comb begin
      sel_hit = 1'b0;
      for (int i = 0; i < NUM_SRC; i++)
         if (int'(src_sel) == i + 1 && src_pulse[i]) sel_hit = 1'b1;
   end

   assign free_m = (src_sel == '0) && !trig_mode;
   assign sync_m = (src_sel != '0) && !trig_mode;
   assign hw_m   = (src_sel != '0) && trig_mode;

   assert_free_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      free_m && tick |=> count == OUT_W'($past(count) + 1'b1));

   assert_free_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      free_m && !tick |=> $stable(count));

   assert_sync_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      sync_m && sel_hit |=> count == '0);

   assert_hw_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
      hw_m && sel_hit && !trig_wr |=> trig_stat);

   assert_wait_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
      trig_mode && !trig_stat |=> count == '0);

   assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      trig_mode && trig_wr && !trig_wr_val |=> !trig_stat);

   assert_stat_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !trig_mode |=> !trig_stat);

   assert_no_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
      trig_mode && (int'(src_sel) > NUM_SRC) && !trig_stat && !trig_wr |=> !trig_stat);

   if (CASCADE) begin : g_casc_chk
      assert_carry_R10: assert property (@(posedge clk) disable iff (!rst_n)
         free_m && !(tick && count[HALF_W-1:0] == '1)
         |=> count[OUT_W-1:HALF_W] == $past(count[OUT_W-1:HALF_W]));
   end
endmodule

bind capture_timebase capture_timebase_chk #(
   .HALF_W (HALF_W),
   .SEL_W  (SEL_W),
   .NUM_SRC(NUM_SRC),
   .CASCADE(CASCADE)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .tick        (tick),
   .src_sel     (src_sel),
   .trig_mode   (trig_mode),
   .src_pulse   (src_pulse),
   .trig_wr     (trig_wr),
   .trig_wr_val (trig_wr_val),
   .count       (count),
   .trig_stat   (trig_stat)
);

// File: tb/capture_timebase_tb.sv
`timescale 1ns/1ps
module capture_timebase_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick = 1'b0;
   logic [4:0]  src_sel = '0;
   logic        trig_mode = 1'b0;
   logic [29:0] src_pulse = '0;
   logic        trig_wr = 1'b0;
   logic        trig_wr_val = 1'b0;
   logic [15:0] count;
   logic        trig_stat;
   logic [31:0] count32;
   logic        trig_stat32;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   capture_timebase u_dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .src_sel(src_sel), .trig_mode(trig_mode),
      .src_pulse(src_pulse), .trig_wr(trig_wr), .trig_wr_val(trig_wr_val),
      .count(count), .trig_stat(trig_stat)
   );

   capture_timebase #(.CASCADE(1'b1)) u_dut_cas (
      .clk(clk), .rst_n(rst_n), .tick(tick), .src_sel(src_sel), .trig_mode(trig_mode),
      .src_pulse(src_pulse), .trig_wr(trig_wr), .trig_wr_val(trig_wr_val),
      .count(count32), .trig_stat(trig_stat32)
   );

   typedef struct packed {
      logic [4:0]  sel;
      logic        tm;
      logic [29:0] pul;
      logic        tk;
      logic        wr;
      logic        wv;
      logic [15:0] cnt;
      logic        st;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 21;
   localparam vec_t VECS [NV] = '{
      '{5'd0,  1'b0, 30'h0,        1'b1, 1'b0, 1'b0, 16'd1, 1'b0, 4'd2},  // R2 step
      '{5'd0,  1'b0, 30'h0,        1'b1, 1'b0, 1'b0, 16'd2, 1'b0, 4'd2},
      '{5'd0,  1'b0, 30'h0,        1'b0, 1'b0, 1'b0, 16'd2, 1'b0, 4'd2},  // R2 hold
      '{5'd0,  1'b0, 30'h0,        1'b1, 1'b0, 1'b0, 16'd3, 1'b0, 4'd2},
      '{5'd3,  1'b0, 30'h4,        1'b1, 1'b0, 1'b0, 16'd0, 1'b0, 4'd4},  // R4 sync beats tick
      '{5'd3,  1'b0, 30'h0,        1'b1, 1'b0, 1'b0, 16'd1, 1'b0, 4'd4},  // R4 resume
      '{5'd3,  1'b0, 30'h8,        1'b1, 1'b0, 1'b0, 16'd2, 1'b0, 4'd4},  // R4 other line
      '{5'd3,  1'b0, 30'h4,        1'b0, 1'b0, 1'b0, 16'd0, 1'b0, 4'd4},
      '{5'd31, 1'b0, 30'h3FFFFFFF, 1'b1, 1'b0, 1'b0, 16'd1, 1'b0, 4'd9},  // R9 sync none
      '{5'd5,  1'b1, 30'h0,        1'b1, 1'b0, 1'b0, 16'd0, 1'b0, 4'd5},  // R5 waiting
      '{5'd5,  1'b1, 30'h10,       1'b1, 1'b0, 1'b0, 16'd0, 1'b1, 4'd5},  // R5 accept
      '{5'd5,  1'b1, 30'h0,        1'b1, 1'b0, 1'b0, 16'd1, 1'b1, 4'd5},
      '{5'd5,  1'b1, 30'h0,        1'b1, 1'b0, 1'b0, 16'd2, 1'b1, 4'd7},  // R7 stays
      '{5'd5,  1'b1, 30'h10,       1'b0, 1'b1, 1'b0, 16'd2, 1'b0, 4'd7},  // R7 clear beats pulse
      '{5'd5,  1'b1, 30'h0,        1'b1, 1'b0, 1'b0, 16'd0, 1'b0, 4'd7},  // R7 back to wait
      '{5'd31, 1'b1, 30'h3FFFFFFF, 1'b1, 1'b0, 1'b0, 16'd0, 1'b0, 4'd9},  // R9 trig none
      '{5'd0,  1'b1, 30'h3FFFFFFF, 1'b1, 1'b0, 1'b0, 16'd0, 1'b0, 4'd6},  // R6 pulses ignored
      '{5'd0,  1'b1, 30'h0,        1'b1, 1'b1, 1'b1, 16'd0, 1'b1, 4'd6},  // R6 sw set
      '{5'd0,  1'b1, 30'h0,        1'b1, 1'b0, 1'b0, 16'd1, 1'b1, 4'd6},
      '{5'd0,  1'b0, 30'h0,        1'b1, 1'b1, 1'b1, 16'd2, 1'b0, 4'd8},  // R8 write ignored
      '{5'd0,  1'b0, 30'h0,        1'b0, 1'b1, 1'b1, 16'd2, 1'b0, 4'd8}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      tick = 1'b0; src_sel = '0; trig_mode = 1'b0; src_pulse = '0;
      trig_wr = 1'b0; trig_wr_val = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      do_reset();
      // R1 reset state
      chk("R1 count", 32'(count), 32'd0);
      chk("R1 status", 32'(trig_stat), 32'd0);
      chk("R1 cascade count", count32, 32'd0);

      for (int i = 0; i < NV; i++) begin
         src_sel = VECS[i].sel; trig_mode = VECS[i].tm; src_pulse = VECS[i].pul;
         tick = VECS[i].tk; trig_wr = VECS[i].wr; trig_wr_val = VECS[i].wv;
         @(negedge clk);
         chk($sformatf("R%0d count v%0d", VECS[i].req, i), 32'(count), 32'(VECS[i].cnt));
         chk($sformatf("R%0d status v%0d", VECS[i].req, i), 32'(trig_stat), 32'(VECS[i].st));
      end

      // R3 wrap and R10 carry in free mode
      do_reset();
      tick = 1'b1;
      repeat (65535) @(posedge clk);
      @(negedge clk);
      chk("R3 at max", 32'(count), 32'h0000FFFF);
      chk("R10 low full", count32, 32'h0000FFFF);
      @(negedge clk);
      tick = 1'b0;
      chk("R3 wrap", 32'(count), 32'd0);
      chk("R10 carry", count32, 32'h00010000);
      tick = 1'b1;
      @(negedge clk);
      chk("R10 no extra carry", count32, 32'h00010001);
      // R10 sync clears both halves
      src_sel = 5'd1; src_pulse = 30'h1;
      @(negedge clk);
      src_pulse = '0; tick = 1'b0;
      chk("R10 sync clear", count32, 32'd0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule